// File: doc/BRIEF.md
# Dual-mode 8-bit PWM and interval timer

This block is a single 8-bit count engine with two output behaviours. In interval mode the counter climbs from zero to a compare value, then reloads to zero and flips a square-wave output. One interval is (compare + 1) count ticks, so the output frequency is the tick rate divided by 2 × (compare + 1). In PWM mode the counter runs freely through 256 steps. The output is high while the count is below the compare value, which gives duty ratios from 0 up to 255/256.

Count ticks come from a selector. It picks a one-cycle enable at the system clock rate, the same enable divided by 16 or by 64 from a free-running prescaler, or an external single-cycle tick, for example from another timer. A run enable holds the whole block idle when it is low. While idle, the counter and prescaler sit at zero and the output is low. Any change to the compare value is taken up only at the next reload or wrap, so a period is never cut short. Each instance keeps all of its state to itself, so two instances can run side by side with different settings.

Top module: `pwm_interval_timer`

## Requirements
- R1: While reset is asserted or `run_en` is low, `wave_out` is 0 and the counter is held at 0. After `run_en` rises, counting starts again from 0, as if the block were fresh.
- R2: In interval mode (`mode_pwm`=0), `wave_out` toggles once every (latched compare + 1) count ticks. The first toggle after enabling drives it high.
- R3: `clk_sel` encoding: 0 gives a tick every clock cycle, 1 gives a tick every 16 cycles, 2 gives a tick every 64 cycles, and 3 uses `ext_tick`. For the divided sources, the first tick comes on the 16th or the 64th clock edge after `run_en` rises.
- R4: With `clk_sel`=3, each clock cycle in which `ext_tick` is high advances the count by exactly one. Cycles with `ext_tick` low do not advance it.
- R5: In PWM mode (`mode_pwm`=1) one period is 256 ticks. After T ticks, `wave_out` is 1 exactly when (T mod 256) < latched compare.
- R6: In PWM mode a compare of 0 gives a constant low output. A compare of 255 gives 255 high ticks and 1 low tick per period.
- R7: A new `cmp_val` takes effect only at the next reload (interval mode) or at the next 255→0 wrap (PWM mode). While `run_en` is low, `cmp_val` is taken up directly.
- R8: Two instances share nothing but clock and reset. An idle instance stays low while the other runs, and two running instances each follow their own settings.
- R9: In interval mode a compare of 0 makes `wave_out` toggle on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Run enable; low clears the counter and prescaler and forces the output low |
| mode_pwm | input | 1 | 1 selects PWM mode, 0 selects interval mode |
| clk_sel | input | 2 | Tick source: 0 every cycle, 1 every 16 cycles, 2 every 64 cycles, 3 external |
| cmp_val | input | 8 | Compare value |
| ext_tick | input | 1 | External synchronous single-cycle count enable |
| wave_out | output | 1 | Square-wave or PWM output |

## Verification
The output is a combinational decode of registers, so a tick taken at a clock edge shows on `wave_out` straight after that edge. With clock-rate ticks, the output after n edges since enable reflects n ticks. With the divided sources it reflects floor(n/16) or floor(n/64) ticks. With the external source it reflects the number of high `ext_tick` cycles that were sampled. Dropping `run_en` pulls the output low within the same cycle. The bench drives inputs and samples at falling edges, and it counts rising edges since enable. It compares the output against closed-form formulas: toggle count floor(T/(C+1)) for interval mode, and (T mod 256) < C for PWM mode. When the compare value changes mid-run, the bench switches to the new value at the tick where the reload or wrap is due.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int PIT_CNT_W = 8;

  typedef enum logic [1:0] {
    SEL_DIV1  = 2'd0,
    SEL_DIV16 = 2'd1,
    SEL_DIV64 = 2'd2,
    SEL_EXT   = 2'd3
  } pit_src_e;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler
  import pit_pkg::*;
#(
  parameter int DIV_A = 16,
  parameter int DIV_B = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic [1:0] clk_sel,
  input  logic       ext_tick,
  output logic       tick
);
  localparam int PRE_W = $clog2(DIV_B);
  localparam int RATIO [2] = '{DIV_A, DIV_B};

  logic [PRE_W-1:0] div_cnt;
  logic [1:0]       div_tick;
  logic             sel_tick;

  // Free-running divider, parked at zero while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_cnt <= '0;
    else if (!run_en) div_cnt <= '0;
    else              div_cnt <= div_cnt + 1'b1;
  end

  // One decode per fixed ratio (ratios are powers of two dividing DIV_B)
  for (genvar g = 0; g < 2; g++) begin : g_ratio
    localparam logic [PRE_W-1:0] MASK = PRE_W'(RATIO[g] - 1);
    assign div_tick[g] = ((div_cnt & MASK) == MASK);
  end

  always_comb begin
    case (pit_src_e'(clk_sel))
      SEL_DIV1:  sel_tick = 1'b1;
      SEL_DIV16: sel_tick = div_tick[0];
      SEL_DIV64: sel_tick = div_tick[1];
      default:   sel_tick = ext_tick;
    endcase
  end

  assign tick = run_en & sel_tick;
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CNT_W = pit_pkg::PIT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             mode_pwm,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_lat,
  output logic             reload
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  // Last count of a period: full scale in PWM mode, compare value otherwise
  function automatic logic period_end(input logic pwm, input logic [CNT_W-1:0] c,
                                      input logic [CNT_W-1:0] m);
    return pwm ? (c == CNT_TOP) : (c == m);
  endfunction

  assign reload = tick & period_end(mode_pwm, cnt_q, cmp_lat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmp_lat <= '0;
    end else if (!run_en) begin
      cnt_q   <= '0;
      cmp_lat <= cmp_val;
    end else if (reload) begin
      cnt_q   <= '0;
      cmp_lat <= cmp_val;
    end else if (tick) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pit_wave.sv
module pit_wave #(
  parameter int CNT_W = pit_pkg::PIT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             mode_pwm,
  input  logic             reload,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cmp_lat,
  output logic             wave_out
);
  logic tog_q;
  logic toggle_evt;

  function automatic logic duty_high(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] m);
    return c < m;
  endfunction

  assign toggle_evt = reload & ~mode_pwm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tog_q <= 1'b0;
    else if (!run_en)    tog_q <= 1'b0;
    else if (toggle_evt) tog_q <= ~tog_q;
  end

  assign wave_out = run_en & (mode_pwm ? duty_high(cnt_q, cmp_lat) : tog_q);
endmodule

// File: rtl/pwm_interval_timer.sv
module pwm_interval_timer #(
  parameter int CNT_W = pit_pkg::PIT_CNT_W,
  parameter int DIV_A = 16,
  parameter int DIV_B = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             mode_pwm,
  input  logic [1:0]       clk_sel,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             ext_tick,
  output logic             wave_out
);
  logic             cnt_tick;
  logic             cnt_reload;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_lat;

  pit_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .clk_sel(clk_sel),
    .ext_tick(ext_tick), .tick(cnt_tick)
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_pwm(mode_pwm),
    .tick(cnt_tick), .cmp_val(cmp_val), .cnt_q(cnt_q), .cmp_lat(cmp_lat),
    .reload(cnt_reload)
  );

  pit_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_pwm(mode_pwm),
    .reload(cnt_reload), .cnt_q(cnt_q), .cmp_lat(cmp_lat), .wave_out(wave_out)
  );
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int CNT_W = pit_pkg::PIT_CNT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             mode_pwm,
  input logic [1:0]       clk_sel,
  input logic             ext_tick,
  input logic             wave_out,
  input logic             tick,
  input logic             reload,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_lat
);
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt_q == '0)); // R1
  AST_INTERVAL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !mode_pwm && reload) |=> (!run_en || mode_pwm || wave_out != $past(wave_out))); // R2
  AST_INTERVAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !mode_pwm && !reload) |=> (!run_en || mode_pwm || $stable(wave_out))); // R2
  AST_DIV16_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && clk_sel == pit_pkg::SEL_DIV16 && tick) |=> (clk_sel != pit_pkg::SEL_DIV16 || !tick)); // R3
  AST_EXT_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && clk_sel == pit_pkg::SEL_EXT && !ext_tick) |=> (!run_en || $stable(cnt_q))); // R4
  AST_PWM_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && mode_pwm && cmp_lat == '0) |-> !wave_out); // R6
  AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !reload) |=> (!run_en || $stable(cmp_lat))); // R7
endmodule

bind pwm_interval_timer pit_checker #(.CNT_W(CNT_W)) u_pit_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_pwm(mode_pwm),
  .clk_sel(clk_sel), .ext_tick(ext_tick), .wave_out(wave_out),
  .tick(cnt_tick), .reload(cnt_reload), .cnt_q(cnt_q), .cmp_lat(cmp_lat)
);

// File: tb/tb_pwm_interval_timer.sv
`timescale 1ns/1ps
module tb_pwm_interval_timer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       run_en = 1'b0, mode_pwm = 1'b0, ext_tick = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic [7:0] cmp_val = 8'd0;
  logic       wave_a;
  logic       b_run_en = 1'b0, b_mode_pwm = 1'b0, b_ext_tick = 1'b0;
  logic [1:0] b_clk_sel = 2'd0;
  logic [7:0] b_cmp_val = 8'd0;
  logic       wave_b;

  int n_chk = 0;
  int n_bad = 0;

  pwm_interval_timer dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_pwm(mode_pwm),
    .clk_sel(clk_sel), .cmp_val(cmp_val), .ext_tick(ext_tick), .wave_out(wave_a)
  );
  pwm_interval_timer dut2 (
    .clk(clk), .rst_n(rst_n), .run_en(b_run_en), .mode_pwm(b_mode_pwm),
    .clk_sel(b_clk_sel), .cmp_val(b_cmp_val), .ext_tick(b_ext_tick), .wave_out(wave_b)
  );

  task automatic chk(input string req, input logic got, input logic exp, input int at);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at step %0d: got %0b expected %0b", req, at, got, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] s);
    return (s == 2'd1) ? 16 : (s == 2'd2) ? 64 : 1;
  endfunction

  function automatic logic exp_interval(input int t, input int c);
    return ((t / (c + 1)) % 2) == 1;
  endfunction

  function automatic logic exp_pwm(input int t, input int c);
    return (t % 256) < c;
  endfunction

  task automatic arm(input logic m, input logic [1:0] s, input logic [7:0] c);
    @(negedge clk);
    run_en = 1'b0; mode_pwm = m; clk_sel = s; cmp_val = c; ext_tick = 1'b0;
    repeat (2) @(negedge clk);
    run_en = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; run_en = 1'b1; mode_pwm = 1'b1; cmp_val = 8'd200;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 reset low", wave_a, 1'b0, i);
    end
    run_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle low", wave_a, 1'b0, 0);
  endtask

  task automatic t_interval(input logic [1:0] s, input int c, input int ncyc, input string req);
    arm(1'b0, s, 8'(c));
    for (int n = 1; n <= ncyc; n++) begin
      @(negedge clk);
      chk(req, wave_a, exp_interval(n / div_of(s), c), n);
    end
    chk("R8 idle peer", wave_b, 1'b0, ncyc);
  endtask

  task automatic t_pwm(input logic [1:0] s, input int c, input int ncyc, input string req);
    arm(1'b1, s, 8'(c));
    for (int n = 1; n <= ncyc; n++) begin
      @(negedge clk);
      chk(req, wave_a, exp_pwm(n / div_of(s), c), n);
    end
  endtask

  // R4: external ticks, two of every three cycles asserted
  task automatic t_ext(input logic m, input int c, input int ncyc);
    int t = 0;
    arm(m, 2'd3, 8'(c));
    for (int n = 1; n <= ncyc; n++) begin
      ext_tick = ((n % 3) != 1);
      @(negedge clk);
      if ((n % 3) != 1) t++;
      chk("R4 ext tick", wave_a, m ? exp_pwm(t, c) : exp_interval(t, c), n);
    end
    ext_tick = 1'b0;
  endtask

  // R7: compare change in PWM mode waits for the wrap at tick 256
  task automatic t_cmp_pwm();
    arm(1'b1, 2'd0, 8'd64);
    for (int n = 1; n <= 600; n++) begin
      if (n == 101) cmp_val = 8'd200;
      @(negedge clk);
      chk("R7 pwm cmp update", wave_a, exp_pwm(n, (n < 256) ? 64 : 200), n);
    end
  endtask

  // R7: interval 9 -> 3 changed mid-interval; reloads at 10, 20, then every 4
  task automatic t_cmp_int();
    int tg;
    arm(1'b0, 2'd0, 8'd9);
    for (int n = 1; n <= 40; n++) begin
      if (n == 15) cmp_val = 8'd3;
      @(negedge clk);
      tg = (n < 10) ? 0 : (n < 20) ? 1 : 2 + (n - 20) / 4;
      chk("R7 interval cmp update", wave_a, logic'(tg % 2), n);
    end
  endtask

  task automatic t_disable();
    arm(1'b0, 2'd0, 8'd2);
    repeat (4) @(negedge clk);
    chk("R1 pre-disable", wave_a, 1'b1, 4);
    run_en = 1'b0;
    #1;
    chk("R1 drop low", wave_a, 1'b0, 0);
    repeat (2) @(negedge clk);
    chk("R1 stay low", wave_a, 1'b0, 1);
    run_en = 1'b1;
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      chk("R1 restart from zero", wave_a, exp_interval(n, 2), n);
    end
  endtask

  task automatic t_dual();
    @(negedge clk);
    run_en = 1'b0; b_run_en = 1'b0;
    mode_pwm = 1'b0; clk_sel = 2'd1; cmp_val = 8'd2;
    b_mode_pwm = 1'b1; b_clk_sel = 2'd0; b_cmp_val = 8'd100;
    repeat (2) @(negedge clk);
    run_en = 1'b1; b_run_en = 1'b1;
    for (int n = 1; n <= 700; n++) begin
      @(negedge clk);
      chk("R8 instance A", wave_a, exp_interval(n / 16, 2), n);
      chk("R8 instance B", wave_b, exp_pwm(n, 100), n);
    end
    b_run_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_interval(2'd0, 4, 40, "R2 interval div1");
    t_interval(2'd0, 0, 20, "R9 interval cmp zero");
    t_interval(2'd1, 3, 300, "R3 interval div16");
    t_interval(2'd2, 3, 1100, "R3 interval div64");
    t_pwm(2'd0, 77, 600, "R5 pwm div1");
    t_pwm(2'd0, 0, 300, "R6 pwm cmp zero");
    t_pwm(2'd0, 255, 600, "R6 pwm cmp full");
    t_pwm(2'd1, 128, 4200, "R3 pwm div16");
    t_ext(1'b0, 5, 60);
    t_ext(1'b1, 40, 500);
    t_cmp_pwm();
    t_cmp_int();
    t_disable();
    t_dual();
    finish_run();
  end
endmodule